// File: doc/BRIEF.md
# Five-stage RV32I integer pipeline for padded instruction streams

This block is an in-order integer core for the 32-bit base RISC-V instruction set. It has five stages: fetch, decode, execute, memory access and write-back. Pipeline registers separate the stages. The core assumes that the program loader places four no-op instructions after every real instruction. Because of that spacing, only one real instruction is in flight at any time. The core therefore has no forwarding, stall or flush logic. Each instruction's control strobes simply travel with it from stage to stage.

Instructions come from a combinational, word-addressed read port. The fetch address is the byte program counter with its two low bits dropped. Data memory is a single word-addressed port with a combinational read, a write strobe and four byte enables.

The register file is internal, with two combinational read ports and one write port. The write port is driven only by the instruction in write-back. Branches and jumps are resolved in execute. Their target replaces the sequential address on the next fetch, and the padding no-ops absorb the two slots fetched in the meantime.

Top module: `rvp_core`

## Requirements
- R1: While `rst` is high and in the cycle after it falls, `imemAddr` is 0 and `dmemWrEn` is 0. Without a taken control transfer, `imemAddr` then rises by one word every cycle.
- R2: The register-register operations produce standard RV32I results: ADD, SUB, SLL, SLT, SLTU, XOR, SRL, SRA, OR and AND. Shift amounts use only the low five bits of the second operand.
- R3: ADDI adds its sign-extended 12-bit immediate. LUI writes its 20-bit immediate shifted left by 12. AUIPC writes the byte address of the AUIPC plus its immediate shifted left by 12.
- R4: Register x0 reads as zero, and a write aimed at it leaves it zero.
- R5: Loads return a whole word (funct3 2), a sign-extended byte (0) or halfword (1), or a zero-extended byte (4) or halfword (5). The lane is selected by address bits [1:0].
- R6: Stores set `dmemByteEn` to 1 shifted left by address bits [1:0] for a byte (funct3 0). For a halfword (1) they set 0011 or 1100, chosen by address bit 1. For a word (2) they set 1111. Byte data is repeated in all four lanes and halfword data in both halves.
- R7: `dmemWrEn` is high only for stores. A store fetched in cycle c raises it in cycle c+3, and it is low in cycle c+2.
- R8: The six conditional branches (funct3 0 BEQ, 1 BNE, 4 BLT, 5 BGE, 6 BLTU, 7 BGEU) are taken exactly when their comparison holds. A branch or jump fetched in cycle c makes `imemAddr` equal its target word in cycle c+3. A branch that is not taken continues in sequence.
- R9: JAL and JALR write the byte address of the jump plus 4 to rd. JALR jumps to rs1 plus its immediate with bit 0 cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| imemAddr | output | IMEM_AW | Instruction word address (PC[IMEM_AW+1:2]) |
| imemData | input | 32 | Instruction word at `imemAddr`, same cycle |
| dmemAddr | output | DMEM_AW | Data word address |
| dmemWrEn | output | 1 | Data write strobe |
| dmemByteEn | output | 4 | Byte lanes written when `dmemWrEn` is high |
| dmemWrData | output | 32 | Lane-replicated store data |
| dmemRdData | input | 32 | Data word at `dmemAddr`, same cycle |

## Verification
The fetch address for a cycle is checked before the following edge. A store's strobe is checked three cycles after the store's fetch cycle, with the strobe required to be low one cycle earlier. For a taken jump, the target word must appear on `imemAddr` three cycles after the jump's fetch cycle, which the bench samples at the falling edge.

A register result is not observable at the ports until a later store moves it out. The program therefore follows every result-producing instruction with a padded store into its own result slot. After the program drains, the bench compares every slot with a value it computes from the requirement. Every strobe is also counted against the number of stores the program contains.

// File: rtl/rvp_pkg.sv
package rvp_pkg;
  localparam int XLEN = 32;

  localparam logic [6:0] OPC_LOAD   = 7'h03;
  localparam logic [6:0] OPC_OPIMM  = 7'h13;
  localparam logic [6:0] OPC_AUIPC  = 7'h17;
  localparam logic [6:0] OPC_STORE  = 7'h23;
  localparam logic [6:0] OPC_OP     = 7'h33;
  localparam logic [6:0] OPC_LUI    = 7'h37;
  localparam logic [6:0] OPC_BRANCH = 7'h63;
  localparam logic [6:0] OPC_JALR   = 7'h67;
  localparam logic [6:0] OPC_JAL    = 7'h6f;

  localparam logic [31:0] NOP_WORD = 32'h0000_0013;

  typedef enum logic [3:0] {
    ALU_NONE, ALU_ADD, ALU_SUB, ALU_SLL, ALU_SLT, ALU_SLTU,
    ALU_XOR, ALU_SRL, ALU_SRA, ALU_OR, ALU_AND, ALU_PASSB
  } aluOpT;

  typedef enum logic [1:0] { WB_ALU, WB_MEM, WB_LINK } wbSelT;

  typedef struct packed {
    logic       regWr;
    logic       memRd;
    logic       memWr;
    logic       branch;
    logic       jump;
    logic       jalr;
    logic       op1Pc;
    logic       op2Imm;
    wbSelT      wbSel;
    aluOpT      aluOp;
    logic [2:0] funct3;
  } ctrlT;

  localparam ctrlT CTRL_BUBBLE = '0;
endpackage

// File: rtl/rvp_alu.sv
module rvp_alu
  import rvp_pkg::*;
(
  input  aluOpT            op,
  input  logic [XLEN-1:0]  a,
  input  logic [XLEN-1:0]  b,
  output logic [XLEN-1:0]  y
);
  localparam int SH_W = $clog2(XLEN);
  logic [SH_W-1:0] shamt;
  assign shamt = b[SH_W-1:0];

  always_comb begin
    unique case (op)
      ALU_ADD:   y = a + b;
      ALU_SUB:   y = a - b;
      ALU_SLL:   y = a << shamt;
      ALU_SLT:   y = {{(XLEN-1){1'b0}}, $signed(a) < $signed(b)};
      ALU_SLTU:  y = {{(XLEN-1){1'b0}}, a < b};
      ALU_XOR:   y = a ^ b;
      ALU_SRL:   y = a >> shamt;
      ALU_SRA:   y = $unsigned($signed(a) >>> shamt);
      ALU_OR:    y = a | b;
      ALU_AND:   y = a & b;
      ALU_PASSB: y = b;
      default:   y = '0;
    endcase
  end
endmodule

// File: rtl/rvp_ctrl.sv
module rvp_ctrl
  import rvp_pkg::*;
(
  input  logic [31:0]     instr,
  output ctrlT            ctrl,
  output logic [XLEN-1:0] imm
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic       alt;
  aluOpT      arith;

  assign opc = instr[6:0];
  assign f3  = instr[14:12];
  assign alt = instr[30];

  always_comb begin
    unique case (f3)
      3'd0:    arith = (opc == OPC_OP && alt) ? ALU_SUB : ALU_ADD;
      3'd1:    arith = ALU_SLL;
      3'd2:    arith = ALU_SLT;
      3'd3:    arith = ALU_SLTU;
      3'd4:    arith = ALU_XOR;
      3'd5:    arith = alt ? ALU_SRA : ALU_SRL;
      3'd6:    arith = ALU_OR;
      default: arith = ALU_AND;
    endcase
  end

  always_comb begin
    ctrl = CTRL_BUBBLE;
    ctrl.funct3 = f3;
    imm = {{20{instr[31]}}, instr[31:20]};
    unique case (opc)
      OPC_OP: begin
        ctrl.regWr = 1'b1; ctrl.aluOp = arith;
      end
      OPC_OPIMM: begin
        ctrl.regWr = 1'b1; ctrl.op2Imm = 1'b1; ctrl.aluOp = arith;
      end
      OPC_LOAD: begin
        ctrl.regWr = 1'b1; ctrl.memRd = 1'b1; ctrl.op2Imm = 1'b1;
        ctrl.aluOp = ALU_ADD; ctrl.wbSel = WB_MEM;
      end
      OPC_STORE: begin
        ctrl.memWr = 1'b1; ctrl.op2Imm = 1'b1; ctrl.aluOp = ALU_ADD;
        imm = {{20{instr[31]}}, instr[31:25], instr[11:7]};
      end
      OPC_BRANCH: begin
        ctrl.branch = 1'b1;
        imm = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
      end
      OPC_JAL: begin
        ctrl.jump = 1'b1; ctrl.regWr = 1'b1; ctrl.wbSel = WB_LINK;
        imm = {{11{instr[31]}}, instr[31], instr[19:12], instr[20], instr[30:21], 1'b0};
      end
      OPC_JALR: begin
        ctrl.jump = 1'b1; ctrl.jalr = 1'b1; ctrl.regWr = 1'b1;
        ctrl.op2Imm = 1'b1; ctrl.aluOp = ALU_ADD; ctrl.wbSel = WB_LINK;
      end
      OPC_LUI: begin
        ctrl.regWr = 1'b1; ctrl.op2Imm = 1'b1; ctrl.aluOp = ALU_PASSB;
        imm = {instr[31:12], 12'b0};
      end
      OPC_AUIPC: begin
        ctrl.regWr = 1'b1; ctrl.op1Pc = 1'b1; ctrl.op2Imm = 1'b1; ctrl.aluOp = ALU_ADD;
        imm = {instr[31:12], 12'b0};
      end
      default: ctrl = CTRL_BUBBLE;
    endcase
  end
endmodule

// File: rtl/rvp_datapath.sv
module rvp_datapath
  import rvp_pkg::*;
#(
  parameter int IMEM_AW = 10,
  parameter int DMEM_AW = 10,
  parameter int NREG    = 32
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] imemAddr,
  input  logic [31:0]        imemData,
  output logic [31:0]        idInstr,
  input  ctrlT               idCtrl,
  input  logic [XLEN-1:0]    idImm,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic               dmemWrEn,
  output logic [3:0]         dmemByteEn,
  output logic [31:0]        dmemWrData,
  input  logic [31:0]        dmemRdData
);
  localparam int RIDX_W = $clog2(NREG);

  // fetch
  logic [XLEN-1:0] pc;
  logic            exRedirect;
  logic [XLEN-1:0] exTarget;

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= exRedirect ? exTarget : pc + 4;
  end
  assign imemAddr = pc[IMEM_AW+1:2];

  // fetch -> decode
  logic [XLEN-1:0] idPc;
  always_ff @(posedge clk) begin
    if (rst) begin idInstr <= NOP_WORD; idPc <= '0; end
    else     begin idInstr <= imemData; idPc <= pc; end
  end

  // register file
  logic [XLEN-1:0]   rf [NREG];
  logic [RIDX_W-1:0] idRs1, idRs2, idRd;
  logic [XLEN-1:0]   idRs1v, idRs2v;
  logic              wbRegWr;
  logic [RIDX_W-1:0] wbRd;
  logic [XLEN-1:0]   wbData;

  assign idRs1  = idInstr[15 +: RIDX_W];
  assign idRs2  = idInstr[20 +: RIDX_W];
  assign idRd   = idInstr[7 +: RIDX_W];
  assign idRs1v = (idRs1 == '0) ? '0 : rf[idRs1];
  assign idRs2v = (idRs2 == '0) ? '0 : rf[idRs2];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (wbRegWr && wbRd != '0) begin
      rf[wbRd] <= wbData;
    end
  end

  // decode -> execute
  ctrlT              exCtrl;
  logic [XLEN-1:0]   exRs1v, exRs2v, exImm, exPc;
  logic [RIDX_W-1:0] exRd;
  always_ff @(posedge clk) begin
    if (rst) begin
      exCtrl <= CTRL_BUBBLE; exRs1v <= '0; exRs2v <= '0;
      exImm <= '0; exPc <= '0; exRd <= '0;
    end else begin
      exCtrl <= idCtrl; exRs1v <= idRs1v; exRs2v <= idRs2v;
      exImm <= idImm; exPc <= idPc; exRd <= idRd;
    end
  end

  // execute
  logic [XLEN-1:0] aluA, aluB, aluY;
  logic            brTaken;
  assign aluA = exCtrl.op1Pc  ? exPc  : exRs1v;
  assign aluB = exCtrl.op2Imm ? exImm : exRs2v;

  rvp_alu alu (.op(exCtrl.aluOp), .a(aluA), .b(aluB), .y(aluY));

  always_comb begin
    unique case (exCtrl.funct3)
      3'd0:    brTaken = exRs1v == exRs2v;
      3'd1:    brTaken = exRs1v != exRs2v;
      3'd4:    brTaken = $signed(exRs1v) <  $signed(exRs2v);
      3'd5:    brTaken = $signed(exRs1v) >= $signed(exRs2v);
      3'd6:    brTaken = exRs1v <  exRs2v;
      3'd7:    brTaken = exRs1v >= exRs2v;
      default: brTaken = 1'b0;
    endcase
  end
  assign exRedirect = exCtrl.jump | (exCtrl.branch & brTaken);
  assign exTarget   = exCtrl.jalr ? {aluY[XLEN-1:1], 1'b0} : exPc + exImm;

  // execute -> memory
  ctrlT              memCtrl;
  logic [XLEN-1:0]   memAlu, memStore, memLink;
  logic [RIDX_W-1:0] memRd;
  always_ff @(posedge clk) begin
    if (rst) begin
      memCtrl <= CTRL_BUBBLE; memAlu <= '0; memStore <= '0; memLink <= '0; memRd <= '0;
    end else begin
      memCtrl <= exCtrl; memAlu <= aluY; memStore <= exRs2v;
      memLink <= exPc + 4; memRd <= exRd;
    end
  end

  // memory access
  logic [1:0]      lane;
  logic [31:0]     rdShift;
  logic [XLEN-1:0] loadVal, memResult;
  assign lane     = memAlu[1:0];
  assign dmemAddr = memAlu[DMEM_AW+1:2];
  assign dmemWrEn = memCtrl.memWr;
  assign rdShift  = dmemRdData >> {lane, 3'b000};

  always_comb begin
    unique case (memCtrl.funct3[1:0])
      2'd0: begin
        dmemByteEn = 4'b0001 << lane;
        dmemWrData = {4{memStore[7:0]}};
      end
      2'd1: begin
        dmemByteEn = lane[1] ? 4'b1100 : 4'b0011;
        dmemWrData = {2{memStore[15:0]}};
      end
      default: begin
        dmemByteEn = 4'b1111;
        dmemWrData = memStore;
      end
    endcase
  end

  always_comb begin
    unique case (memCtrl.funct3)
      3'd0:    loadVal = {{24{rdShift[7]}}, rdShift[7:0]};
      3'd1:    loadVal = {{16{rdShift[15]}}, rdShift[15:0]};
      3'd4:    loadVal = {24'b0, rdShift[7:0]};
      3'd5:    loadVal = {16'b0, rdShift[15:0]};
      default: loadVal = dmemRdData;
    endcase
  end

  always_comb begin
    unique case (memCtrl.wbSel)
      WB_MEM:  memResult = loadVal;
      WB_LINK: memResult = memLink;
      default: memResult = memAlu;
    endcase
  end

  // memory -> write-back
  always_ff @(posedge clk) begin
    if (rst) begin wbRegWr <= 1'b0; wbRd <= '0; wbData <= '0; end
    else begin wbRegWr <= memCtrl.regWr; wbRd <= memRd; wbData <= memResult; end
  end
endmodule

// File: rtl/rvp_core.sv
module rvp_core
  import rvp_pkg::*;
#(
  parameter int IMEM_AW = 10,
  parameter int DMEM_AW = 10
) (
  input  logic               clk,
  input  logic               rst,
  output logic [IMEM_AW-1:0] imemAddr,
  input  logic [31:0]        imemData,
  output logic [DMEM_AW-1:0] dmemAddr,
  output logic               dmemWrEn,
  output logic [3:0]         dmemByteEn,
  output logic [31:0]        dmemWrData,
  input  logic [31:0]        dmemRdData
);
  logic [31:0]     idInstr;
  ctrlT            idCtrl;
  logic [XLEN-1:0] idImm;

  rvp_ctrl ctl (.instr(idInstr), .ctrl(idCtrl), .imm(idImm));

  rvp_datapath #(.IMEM_AW(IMEM_AW), .DMEM_AW(DMEM_AW)) dp (
    .clk(clk), .rst(rst),
    .imemAddr(imemAddr), .imemData(imemData),
    .idInstr(idInstr), .idCtrl(idCtrl), .idImm(idImm),
    .dmemAddr(dmemAddr), .dmemWrEn(dmemWrEn), .dmemByteEn(dmemByteEn),
    .dmemWrData(dmemWrData), .dmemRdData(dmemRdData)
  );
endmodule

// File: rtl/rvp_core_chk.sv
module rvp_core_chk #(
  parameter int IMEM_AW = 10
) (
  input logic               clk,
  input logic               rst,
  input logic [IMEM_AW-1:0] imemAddr,
  input logic               dmemWrEn,
  input logic [3:0]         dmemByteEn,
  input logic               redirect,
  input logic [IMEM_AW-1:0] target
);
  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (imemAddr == '0 && !dmemWrEn)); // R1

  AST_SEQ_FETCH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(redirect)) |-> imemAddr == $past(imemAddr) + 1'b1); // R1

  AST_REDIRECT_FETCH: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(redirect)) |-> imemAddr == $past(target)); // R8

  AST_LEGAL_LANES: assert property (@(posedge clk) disable iff (rst)
    dmemWrEn |-> (dmemByteEn inside {4'b0001, 4'b0010, 4'b0100, 4'b1000,
                                     4'b0011, 4'b1100, 4'b1111})); // R6
endmodule

bind rvp_core rvp_core_chk #(.IMEM_AW(IMEM_AW)) chk (
  .clk(clk), .rst(rst), .imemAddr(imemAddr),
  .dmemWrEn(dmemWrEn), .dmemByteEn(dmemByteEn),
  .redirect(dp.exRedirect), .target(dp.exTarget[IMEM_AW+1:2])
);

// File: tb/rvp_core_test.sv
`timescale 1ns/1ps
module rvp_core_test;
  localparam int IAW = 10;
  localparam int DAW = 10;
  localparam int SLOT_BASE = 256;
  localparam logic [31:0] NOP = 32'h0000_0013;
  localparam logic [31:0] LDVAL = 32'h7F15_A2B3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [IAW-1:0] imemAddr;
  logic [31:0]    imemData;
  logic [DAW-1:0] dmemAddr;
  logic           dmemWrEn;
  logic [3:0]     dmemByteEn;
  logic [31:0]    dmemWrData;
  logic [31:0]    dmemRdData;

  logic [31:0] imem [1 << IAW];
  logic [31:0] dmem [1 << DAW];

  int total = 0;
  int bad = 0;
  int cur = 0;
  int slot = 0;
  int nStores = 0;
  int firstSw = -1;
  int jalIdx = 0;
  logic [31:0] expv [128];
  string       tagv [128];

  always #2 clk = ~clk;

  rvp_core #(.IMEM_AW(IAW), .DMEM_AW(DAW)) uut (
    .clk(clk), .rst(rst), .imemAddr(imemAddr), .imemData(imemData),
    .dmemAddr(dmemAddr), .dmemWrEn(dmemWrEn), .dmemByteEn(dmemByteEn),
    .dmemWrData(dmemWrData), .dmemRdData(dmemRdData)
  );

  assign imemData   = imem[imemAddr];
  assign dmemRdData = dmem[dmemAddr];

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < (1 << DAW); i++) dmem[i] <= '0;
    end else if (dmemWrEn) begin
      for (int b = 0; b < 4; b++)
        if (dmemByteEn[b]) dmem[dmemAddr][b*8 +: 8] <= dmemWrData[b*8 +: 8];
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // encoders
  function automatic logic [31:0] encR(input logic [6:0] f7, input int rs2, input int rs1,
                                       input logic [2:0] f3, input int rd);
    return {f7, 5'(rs2), 5'(rs1), f3, 5'(rd), 7'h33};
  endfunction
  function automatic logic [31:0] encI(input logic [31:0] imm, input int rs1, input logic [2:0] f3,
                                       input int rd, input logic [6:0] op);
    return {imm[11:0], 5'(rs1), f3, 5'(rd), op};
  endfunction
  function automatic logic [31:0] encS(input logic [31:0] imm, input int rs2, input int rs1,
                                       input logic [2:0] f3);
    return {imm[11:5], 5'(rs2), 5'(rs1), f3, imm[4:0], 7'h23};
  endfunction
  function automatic logic [31:0] encB(input logic [31:0] imm, input int rs2, input int rs1,
                                       input logic [2:0] f3);
    return {imm[12], imm[10:5], 5'(rs2), 5'(rs1), f3, imm[4:1], imm[11], 7'h63};
  endfunction
  function automatic logic [31:0] encJ(input logic [31:0] imm, input int rd);
    return {imm[20], imm[10:1], imm[11], imm[19:12], 5'(rd), 7'h6f};
  endfunction

  task automatic emit(input logic [31:0] w);
    imem[cur] = w; cur++;
    for (int k = 0; k < 4; k++) begin imem[cur] = NOP; cur++; end
  endtask

  task automatic addi(input int rd, input int rs1, input int v);
    emit(encI(32'(v), rs1, 3'd0, rd, 7'h13));
  endtask

  task automatic li(input int rd, input logic [31:0] v);
    logic [31:0] hi, lo;
    hi = (v + 32'h800) >> 12;
    lo = v - (hi << 12);
    emit({hi[19:0], 5'(rd), 7'h37});
    addi(rd, rd, int'($signed(lo)));
  endtask

  task automatic store(input int rs, input logic [31:0] v, input string tag);
    if (firstSw < 0) firstSw = cur;
    emit(encS(32'(SLOT_BASE * 4 + slot * 4), rs, 0, 3'd2));
    expv[slot] = v; tagv[slot] = tag; slot++; nStores++;
  endtask

  function automatic logic [31:0] aluRef(input int i, input logic [31:0] a, input logic [31:0] b);
    case (i)
      0: return a + b;
      1: return a - b;
      2: return a << b[4:0];
      3: return {31'b0, $signed(a) < $signed(b)};
      4: return {31'b0, a < b};
      5: return a ^ b;
      6: return a >> b[4:0];
      7: return $unsigned($signed(a) >>> b[4:0]);
      8: return a | b;
      default: return a & b;
    endcase
  endfunction

  function automatic logic [2:0] f3Of(input int i);
    case (i)
      0, 1: return 3'd0;
      2: return 3'd1;
      3: return 3'd2;
      4: return 3'd3;
      5: return 3'd4;
      6, 7: return 3'd5;
      8: return 3'd6;
      default: return 3'd7;
    endcase
  endfunction

  function automatic bit brRef(input int f, input logic [31:0] a, input logic [31:0] b);
    case (f)
      0: return a == b;
      1: return a != b;
      4: return $signed(a) < $signed(b);
      5: return $signed(a) >= $signed(b);
      6: return a < b;
      default: return a >= b;
    endcase
  endfunction

  task automatic buildProgram();
    int pa [4];
    int pb [4];
    int brF [6];
    int k, auIdx;
    pa = '{-3, 5, 2047, -2048};
    pb = '{5, -3, 31, 1};
    brF = '{0, 1, 4, 5, 6, 7};
    for (int i = 0; i < (1 << IAW); i++) imem[i] = NOP;
    // R2: register-register sweep
    for (int p = 0; p < 4; p++) begin
      addi(1, 0, pa[p]);
      addi(2, 0, pb[p]);
      for (int i = 0; i < 10; i++) begin
        emit(encR((i == 1 || i == 7) ? 7'h20 : 7'h00, 2, 1, f3Of(i), 3));
        store(3, aluRef(i, 32'(pa[p]), 32'(pb[p])), "R2");
      end
    end
    // R3: ADDI, LUI, AUIPC
    addi(16, 0, -1234);
    store(16, 32'(-1234), "R3");
    emit({20'h12345, 5'd4, 7'h37});
    store(4, 32'h1234_5000, "R3");
    auIdx = cur;
    emit({20'h00001, 5'd5, 7'h17});
    store(5, 32'(auIdx * 4) + 32'h1000, "R3");
    // R4: x0 stays zero
    addi(0, 0, 55);
    store(0, 32'h0, "R4");
    // R5: loads at every lane
    li(6, LDVAL);
    emit(encS(32'd32, 6, 0, 3'd2));
    nStores++;
    for (int b = 0; b < 4; b++) begin
      logic [7:0] by;
      by = LDVAL[b*8 +: 8];
      emit(encI(32'(32 + b), 0, 3'd0, 12, 7'h03));
      store(12, {{24{by[7]}}, by}, "R5");
      emit(encI(32'(32 + b), 0, 3'd4, 12, 7'h03));
      store(12, {24'b0, by}, "R5");
    end
    for (int h = 0; h < 2; h++) begin
      logic [15:0] hw;
      hw = LDVAL[h*16 +: 16];
      emit(encI(32'(32 + 2 * h), 0, 3'd1, 12, 7'h03));
      store(12, {{16{hw[15]}}, hw}, "R5");
      emit(encI(32'(32 + 2 * h), 0, 3'd5, 12, 7'h03));
      store(12, {16'b0, hw}, "R5");
    end
    emit(encI(32'd32, 0, 3'd2, 12, 7'h03));
    store(12, LDVAL, "R5");
    // R6: byte and halfword stores
    for (int b = 0; b < 4; b++) begin
      addi(13, 0, 17 * (b + 1));
      emit(encS(32'(36 + b), 13, 0, 3'd0));
      nStores++;
    end
    emit(encI(32'd36, 0, 3'd2, 14, 7'h03));
    store(14, 32'h4433_2211, "R6");
    addi(13, 0, -291);
    emit(encS(32'd40, 13, 0, 3'd1));
    nStores++;
    addi(13, 0, 705);
    emit(encS(32'd42, 13, 0, 3'd1));
    nStores++;
    emit(encI(32'd40, 0, 3'd2, 14, 7'h03));
    store(14, 32'h02C1_FEDD, "R6");
    // R8: all branch conditions with -3 and 5
    addi(1, 0, -3);
    addi(2, 0, 5);
    for (int i = 0; i < 6; i++) begin
      addi(7, 0, 0);
      emit(encB(32'd40, 2, 1, 3'(brF[i])));
      addi(7, 0, 1);
      store(7, brRef(brF[i], 32'(-3), 32'd5) ? 32'd0 : 32'd1, "R8");
    end
    // R9: JAL
    jalIdx = cur;
    emit(encJ(32'd40, 8));
    addi(9, 0, 1);
    emit(NOP);
    store(8, 32'((jalIdx + 1) * 4), "R9");
    store(9, 32'd0, "R9");
    // R9: JALR with odd base address
    k = cur + 10;
    li(10, 32'((k + 10) * 4 + 1));
    emit(encI(32'd0, 10, 3'd0, 11, 7'h67));
    addi(15, 0, 1);
    emit(NOP);
    store(11, 32'((k + 1) * 4), "R9");
    store(15, 32'd0, "R9");
    // spin
    emit(encJ(32'd0, 0));
  endtask

  bit finished = 0;

  initial begin
    int cyc, swCyc, strobes;
    buildProgram();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(imemAddr == '0, "R1", "fetch address in reset", 32'(imemAddr), 0);
    check(dmemWrEn == 1'b0, "R1", "store strobe in reset", 32'(dmemWrEn), 0);
    rst = 1'b0;
    check(imemAddr == '0, "R1", "fetch address at reset release", 32'(imemAddr), 0);
    cyc = 0;
    swCyc = -100;
    strobes = 0;
    for (int n = 0; n < cur + 40; n++) begin
      @(negedge clk);
      cyc++;
      if (dmemWrEn) strobes++;
      if (cyc < 8)
        check(imemAddr == IAW'(cyc), "R1", "sequential fetch", 32'(imemAddr), 32'(cyc));
      if (swCyc < 0 && imemAddr == IAW'(firstSw)) swCyc = cyc;
      if (cyc == swCyc + 2)
        check(!dmemWrEn, "R7", "strobe early", 32'(dmemWrEn), 0);
      if (cyc == swCyc + 3) begin
        check(dmemWrEn, "R7", "strobe on time", 32'(dmemWrEn), 1);
        check(dmemByteEn == 4'b1111, "R6", "word byte enables", 32'(dmemByteEn), 32'hf);
      end
      if (imemAddr == IAW'(jalIdx)) begin
        repeat (3) @(negedge clk);
        cyc += 3;
        check(imemAddr == IAW'(jalIdx + 10), "R8", "jump target fetch",
              32'(imemAddr), 32'(jalIdx + 10));
      end
    end
    check(strobes == nStores, "R7", "store strobe count", 32'(strobes), 32'(nStores));
    for (int s = 0; s < slot; s++)
      check(dmem[SLOT_BASE + s] == expv[s], tagv[s], $sformatf("result slot %0d", s),
            dmem[SLOT_BASE + s], expv[s]);
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #40000;
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule